// File: doc/BRIEF.md
# Operate-Class Execute Unit with Sign Flags

This block is the execute stage for the register-to-register arithmetic and logic instructions of a small 16-bit load/store processor. On a cycle where the execute strobe is high it decodes the 16-bit instruction word. It recognises three operations: addition, bitwise AND and bitwise complement. It reads its operands from an internal bank of eight 16-bit general registers and writes the result back into the bank on the next clock edge.

The second operand of the two-input operations comes from one of two places. It is either a register or a 5-bit two's-complement constant taken from the instruction word and sign-extended to 16 bits. A separate write port lets the memory stage deposit loaded words into the same register bank. Every write to the bank, from either source, also updates a one-hot sign register that reports whether the written word was negative, zero or positive. Later branch logic reads that register. The whole bank and the sign flags are visible at the outputs.

Top module: `opx_core`

## Requirements
- R1: After a synchronous reset, all eight registers read 0 and the flags read N=0, Z=1, P=0.
- R2: With opcode bits [15:12]=4'b0001 and bit 5=0, the register selected by [11:9] receives the 16-bit sum, modulo 2^16, of the registers selected by [8:6] and [2:0].
- R3: With bit 5=1, opcodes 4'b0001 and 4'b0101 use bits [4:0] as a signed 5-bit value sign-extended to 16 bits in place of the second register.
- R4: With opcode 4'b0101, the destination receives the bitwise AND of the two operands.
- R5: With opcode 4'b1001, the destination receives the bitwise complement of the register at [8:6], whatever bits [5:0] hold.
- R6: After every register write, exactly one flag is set. N is set when bit 15 of the written word is 1, Z when the word is zero, and P otherwise.
- R7: A load write (load enable high, with a 3-bit index and a 16-bit word) with no operate write in the same cycle stores the word at the index and sets the flags from that word.
- R8: The register write and the flag update become visible after the clock edge that samples the strobe. A valid instruction word without the strobe changes nothing.
- R9: A strobe with any opcode other than the three above writes no register and leaves the flags unchanged. A load in the same cycle is handled as in R7.
- R10: When an operate write and a load write fall in the same cycle, both are stored if their targets differ, and the operate result wins if they match. In both cases the flags follow the operate result.
- R11: In a cycle with neither a strobe nor a load, all registers and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe; the instruction word is acted on when high |
| instr | input | 16 | Instruction word |
| ld_we | input | 1 | Load write enable |
| ld_idx | input | 3 | Load target register |
| ld_data | input | 16 | Load data word |
| regs_flat | output | 128 | Register bank, register k at bits [16k+15:16k] |
| flag_n | output | 1 | Last written word was negative |
| flag_z | output | 1 | Last written word was zero |
| flag_p | output | 1 | Last written word was positive |

## Verification
An operate write and a load write can fall in the same cycle. That collision decides both which value lands in the bank and which word sets the flags. The bench drives the strobe and the load port together, once with distinct targets and once with the same target. It picks load words whose sign differs from the operate result, so that a flag taken from the wrong source is visible. Each result is judged against the scoreboard's full expected bank and flag state after the edge.

// File: rtl/opx_pkg.sv
package opx_pkg;

    localparam int WORD_W   = 16;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int IMM_W    = 5;
    localparam int OPC_W    = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;

    typedef enum logic [1:0] {
        OPK_NONE,
        OPK_ADD,
        OPK_AND,
        OPK_NOT
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        ridx_t    dst;
        ridx_t    src_a;
        ridx_t    src_b;
        logic     use_imm;
        word_t    imm;
    } dec_t;

    typedef struct packed {
        logic n;
        logic z;
        logic p;
    } sign_t;

    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t data;
    } wr_t;

    localparam sign_t SIGN_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

    function automatic word_t sext_imm(input logic [IMM_W-1:0] v);
        return {{(WORD_W-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic sign_t sign_of(input word_t w);
        sign_t s;
        s.n = w[WORD_W-1];
        s.z = (w == '0);
        s.p = !w[WORD_W-1] && (w != '0);
        return s;
    endfunction

    function automatic dec_t decode(input word_t ins);
        dec_t d;
        unique case (ins[15:12])
            OPC_ADD: d.kind = OPK_ADD;
            OPC_AND: d.kind = OPK_AND;
            OPC_NOT: d.kind = OPK_NOT;
            default: d.kind = OPK_NONE;
        endcase
        d.dst     = ins[11:9];
        d.src_a   = ins[8:6];
        d.src_b   = ins[2:0];
        d.use_imm = ins[5] && (d.kind != OPK_NOT);
        d.imm     = sext_imm(ins[IMM_W-1:0]);
        return d;
    endfunction

endpackage

// File: rtl/opx_decode.sv
module opx_decode
    import opx_pkg::*;
(
    input  logic  strobe,
    input  word_t ins,
    output dec_t  dec,
    output logic  fire
);
    always_comb begin
        dec  = decode(ins);
        fire = strobe && (dec.kind != OPK_NONE);
    end
endmodule

// File: rtl/opx_alu.sv
module opx_alu
    import opx_pkg::*;
(
    input  dec_t  dec,
    input  word_t opa,
    input  word_t opb_reg,
    output word_t res
);
    word_t opb;

    always_comb begin
        opb = dec.use_imm ? dec.imm : opb_reg;
        unique case (dec.kind)
            OPK_ADD: res = opa + opb;
            OPK_AND: res = opa & opb;
            OPK_NOT: res = ~opa;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/opx_regbank.sv
module opx_regbank
    import opx_pkg::*;
#(
    parameter int N = NUM_REGS
) (
    input  logic                clk,
    input  logic                rst,
    input  wr_t                 wa,
    input  wr_t                 wb,
    input  ridx_t               ra,
    input  ridx_t               rb,
    output word_t               qa,
    output word_t               qb,
    output logic [N*WORD_W-1:0] flat
);
    word_t r [N];

    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                r[i] <= '0;
            else if (wa.en && (wa.idx == ridx_t'(i)))
                r[i] <= wa.data;
            else if (wb.en && (wb.idx == ridx_t'(i)))
                r[i] <= wb.data;
        end
        assign flat[i*WORD_W +: WORD_W] = r[i];
    end

    assign qa = r[ra];
    assign qb = r[rb];
endmodule

// File: rtl/opx_signreg.sv
module opx_signreg
    import opx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wr_t   wa,
    input  wr_t   wb,
    output sign_t flags
);
    always_ff @(posedge clk) begin
        if (rst)
            flags <= SIGN_RESET;
        else if (wa.en)
            flags <= sign_of(wa.data);
        else if (wb.en)
            flags <= sign_of(wb.data);
    end
endmodule

// File: rtl/opx_core.sv
module opx_core
    import opx_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           exec_en,
    input  logic [15:0]    instr,
    input  logic           ld_we,
    input  logic [2:0]     ld_idx,
    input  logic [15:0]    ld_data,
    output logic [127:0]   regs_flat,
    output logic           flag_n,
    output logic           flag_z,
    output logic           flag_p
);
    dec_t  dec;
    logic  fire;
    word_t opa, opb, res;
    wr_t   w_op, w_ld;
    sign_t flags;

    opx_decode u_dec (
        .strobe (exec_en),
        .ins    (instr),
        .dec    (dec),
        .fire   (fire)
    );

    opx_alu u_alu (
        .dec     (dec),
        .opa     (opa),
        .opb_reg (opb),
        .res     (res)
    );

    always_comb begin
        w_op.en   = fire;
        w_op.idx  = dec.dst;
        w_op.data = res;
        w_ld.en   = ld_we;
        w_ld.idx  = ld_idx;
        w_ld.data = ld_data;
    end

    opx_regbank #(.N(NUM_REGS)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .wa   (w_op),
        .wb   (w_ld),
        .ra   (dec.src_a),
        .rb   (dec.src_b),
        .qa   (opa),
        .qb   (opb),
        .flat (regs_flat)
    );

    opx_signreg u_sign (
        .clk   (clk),
        .rst   (rst),
        .wa    (w_op),
        .wb    (w_ld),
        .flags (flags)
    );

    assign flag_n = flags.n;
    assign flag_z = flags.z;
    assign flag_p = flags.p;
endmodule

// File: rtl/opx_checker.sv
module opx_checker (
    input logic         clk,
    input logic         rst,
    input logic         exec_en,
    input logic [15:0]  instr,
    input logic         ld_we,
    input logic [2:0]   ld_idx,
    input logic [15:0]  ld_data,
    input logic [127:0] regs_flat,
    input logic         flag_n,
    input logic         flag_z,
    input logic         flag_p
);
    logic [15:0] rv [8];
    logic [2:0]  ld_idx_d, dst_d;
    logic [15:0] ld_data_d, src_d;
    logic        is_op;

    always_comb begin
        for (int i = 0; i < 8; i++) rv[i] = regs_flat[i*16 +: 16];
        is_op = (instr[15:12] == 4'b0001) || (instr[15:12] == 4'b0101) ||
                (instr[15:12] == 4'b1001);
    end

    always_ff @(posedge clk) begin
        ld_idx_d  <= ld_idx;
        ld_data_d <= ld_data;
        dst_d     <= instr[11:9];
        src_d     <= rv[instr[8:6]];
    end

    assert_flags_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $countones({flag_n, flag_z, flag_p}) == 1);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!exec_en && !ld_we) |=> ($stable(regs_flat) && $stable({flag_n, flag_z, flag_p})));

    assert_badop_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (exec_en && !is_op && !ld_we) |=> ($stable(regs_flat) && $stable({flag_n, flag_z, flag_p})));

    assert_load_write_R7: assert property (@(posedge clk) disable iff (rst)
        (ld_we && !exec_en) |=> (rv[ld_idx_d] == ld_data_d && flag_z == (ld_data_d == 16'h0)));

    assert_not_result_R5: assert property (@(posedge clk) disable iff (rst)
        (exec_en && instr[15:12] == 4'b1001 && !ld_we) |=> (rv[dst_d] == ~src_d));

    assert_collide_both_R10: assert property (@(posedge clk) disable iff (rst)
        (exec_en && is_op && ld_we && ld_idx != instr[11:9]) |=> (rv[ld_idx_d] == ld_data_d));
endmodule

bind opx_core opx_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .exec_en   (exec_en),
    .instr     (instr),
    .ld_we     (ld_we),
    .ld_idx    (ld_idx),
    .ld_data   (ld_data),
    .regs_flat (regs_flat),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_p    (flag_p)
);

// File: tb/sim_opx_core.sv
module sim_opx_core;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         exec_en = 1'b0;
    logic [15:0]  instr = 16'h0;
    logic         ld_we = 1'b0;
    logic [2:0]   ld_idx = 3'd0;
    logic [15:0]  ld_data = 16'h0;
    logic [127:0] regs_flat;
    logic         flag_n, flag_z, flag_p;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [15:0] m [8];
    logic [2:0]  mflags;

    logic [127:0] q_regs [$];
    logic [2:0]   q_flags [$];
    string        q_tag [$];

    always #5 clk = ~clk;

    opx_core u0 (
        .clk(clk), .rst(rst), .exec_en(exec_en), .instr(instr),
        .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
        .regs_flat(regs_flat), .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
    );

    function automatic logic [2:0] nzp(input logic [15:0] v);
        return {v[15], v == 16'h0, !v[15] && v != 16'h0};
    endfunction

    function automatic logic [127:0] pack_model();
        logic [127:0] f;
        for (int i = 0; i < 8; i++) f[i*16 +: 16] = m[i];
        return f;
    endfunction

    function automatic logic [15:0] e_add(input logic [2:0] d, s1, s2);
        return {4'b0001, d, s1, 3'b000, s2};
    endfunction
    function automatic logic [15:0] e_addi(input logic [2:0] d, s1, input logic [4:0] k);
        return {4'b0001, d, s1, 1'b1, k};
    endfunction
    function automatic logic [15:0] e_and(input logic [2:0] d, s1, s2);
        return {4'b0101, d, s1, 3'b000, s2};
    endfunction
    function automatic logic [15:0] e_andi(input logic [2:0] d, s1, input logic [4:0] k);
        return {4'b0101, d, s1, 1'b1, k};
    endfunction
    function automatic logic [15:0] e_not(input logic [2:0] d, s, input logic [5:0] low);
        return {4'b1001, d, s, low};
    endfunction

    // driver: applies one cycle of stimulus and pushes the expected state
    task automatic step(input logic ex, input logic [15:0] ins, input logic lw,
                        input logic [2:0] li, input logic [15:0] ldv, input string tag);
        logic [15:0] a, b, r;
        logic        valid;
        @(negedge clk);
        exec_en = ex; instr = ins; ld_we = lw; ld_idx = li; ld_data = ldv;
        a = m[ins[8:6]];
        b = ins[5] ? {{11{ins[4]}}, ins[4:0]} : m[ins[2:0]];
        valid = 1'b1;
        case (ins[15:12])
            4'b0001: r = a + b;
            4'b0101: r = a & b;
            4'b1001: r = ~a;
            default: begin r = 16'h0; valid = 1'b0; end
        endcase
        valid = valid && ex;
        if (valid) begin
            if (lw && li != ins[11:9]) m[li] = ldv;
            m[ins[11:9]] = r;
            mflags = nzp(r);
        end else if (lw) begin
            m[li] = ldv;
            mflags = nzp(ldv);
        end
        q_regs.push_back(pack_model());
        q_flags.push_back(mflags);
        q_tag.push_back(tag);
    endtask

    // monitor: compares each expected item after the edge that produces it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_regs.size() > 0) begin
                logic [127:0] er;
                logic [2:0]   ef;
                string        t;
                er = q_regs.pop_front();
                ef = q_flags.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (regs_flat !== er || {flag_n, flag_z, flag_p} !== ef) begin
                    fails++;
                    $display("FAIL %s: regs=%h nzp=%b expected regs=%h nzp=%b",
                             t, regs_flat, {flag_n, flag_z, flag_p}, er, ef);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m[i] = 16'h0;
        mflags = 3'b010;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        checks++;
        if (regs_flat !== 128'h0 || {flag_n, flag_z, flag_p} !== 3'b010) begin
            fails++;
            $display("FAIL R1: regs=%h nzp=%b expected regs=0 nzp=010",
                     regs_flat, {flag_n, flag_z, flag_p});
        end

        // R7 loads, with each flag outcome
        step(0, 16'h0, 1, 3'd1, 16'h0005, "R7 load positive");
        step(0, 16'h0, 1, 3'd2, 16'hFFFE, "R7 load negative");
        step(0, 16'h0, 1, 3'd3, 16'h0000, "R7 load zero");
        step(0, 16'h0, 1, 3'd4, 16'h7FFF, "R7 load max");
        // R2 register-mode add, including wrap into negative
        step(1, e_add(3'd5, 3'd1, 3'd2), 0, 3'd0, 16'h0, "R2 add reg");
        step(1, e_add(3'd6, 3'd4, 3'd1), 0, 3'd0, 16'h0, "R2 add wrap R6");
        // R3 immediate: -5 gives zero, +15 positive
        step(1, e_addi(3'd5, 3'd1, 5'b11011), 0, 3'd0, 16'h0, "R3 add imm neg");
        step(1, e_addi(3'd6, 3'd1, 5'b01111), 0, 3'd0, 16'h0, "R3 add imm pos");
        // R4 AND register and immediate
        step(1, e_and(3'd7, 3'd2, 3'd4), 0, 3'd0, 16'h0, "R4 and reg");
        step(1, e_andi(3'd0, 3'd2, 5'b00000), 0, 3'd0, 16'h0, "R4 and imm clear");
        step(1, e_andi(3'd0, 3'd2, 5'b10101), 0, 3'd0, 16'h0, "R4 and imm sext");
        // R5 complement, proper and malformed low bits
        step(1, e_not(3'd0, 3'd3, 6'b111111), 0, 3'd0, 16'h0, "R5 not");
        step(1, e_not(3'd1, 3'd4, 6'b000000), 0, 3'd0, 16'h0, "R5 not malformed");
        // R8 back-to-back dependency and no strobe
        step(1, e_add(3'd2, 3'd6, 3'd6), 0, 3'd0, 16'h0, "R8 dep first");
        step(1, e_add(3'd2, 3'd2, 3'd2), 0, 3'd0, 16'h0, "R8 dep second");
        step(0, e_add(3'd3, 3'd2, 3'd2), 0, 3'd0, 16'h0, "R8 no strobe");
        // R9 other opcodes
        step(1, 16'h2A05, 0, 3'd0, 16'h0, "R9 other opcode");
        step(1, 16'hF025, 1, 3'd5, 16'h8001, "R9 other opcode with load");
        // R11 idle
        step(0, 16'h0, 0, 3'd0, 16'h0, "R11 idle");
        // R10 collisions, with load sign opposite to operate result
        step(1, e_addi(3'd3, 3'd6, 5'b00001), 1, 3'd4, 16'h0000, "R10 distinct targets");
        step(1, e_andi(3'd5, 3'd6, 5'b01111), 1, 3'd5, 16'h8000, "R10 same target");
        step(1, e_not(3'd7, 3'd7, 6'b111111), 1, 3'd0, 16'h1234, "R10 flags from operate");
        // R6 flags after a sequence
        step(1, e_add(3'd4, 3'd4, 3'd4), 0, 3'd0, 16'h0, "R6 zero sum");
        step(0, 16'h0, 1, 3'd6, 16'h8000, "R6 load min");

        @(negedge clk);
        exec_en = 1'b0; ld_we = 1'b0;
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule